// File: doc/BRIEF.md
# Lookup Coprocessor Read Responder

This block is the device-side logic of a lookup coprocessor. It answers single-location read instructions that a host issues on a shared 72-bit bidirectional data bus. In the cycle in which the command is valid, the host places an address word on the bus. The word selects the target array, picks direct or indirect addressing, and names the device that must answer.

A device that recognises itself runs a fixed six-cycle turnaround:
- two quiet cycles while the host releases the bus;
- one cycle driving the bus with the handshake held low;
- one cycle presenting the location's data with the handshake high;
- one cycle with the bus released and the handshake low.

After that the handshake returns to high impedance. The tri-state pins are modelled as separate output-enable signals. Every other device on the bus keeps both enables low for the whole instruction. Both arrays and the eight index registers can be preloaded through plain write ports, so their contents are known.

Top module: `lookup_read_responder`

## Requirements
- R1: A read starts only when the block is idle, `cmd_valid` is 1, `cmd[1:0]` equals 2'b01 and `cmd[2]` is 0. Any other command code produces no bus activity.
- R2: In cycles 2 and 3 of a read (the cycles after the command cycle), `ack_oe` and `dq_oe` are both 0.
- R3: In cycle 4 a selected device sets `ack_oe` and `dq_oe` to 1, with `ack_out` at 0.
- R4: In cycle 5 a selected device drives `ack_out` to 1 with `dq_oe` at 1. `dq_out` then carries the word stored at the addressed location, which is the low ADDR_W bits of the location address.
- R5: In cycle 6 `dq_oe` is 0, `ack_oe` is 1 and `ack_out` is 0. From cycle 7 `ack_oe` is 0 and a new read may start.
- R6: The address word has the device ID in bits 25:22 and the bank in bit 21. The device is selected when these equal DEV_ID and DEV_BANK. When bits 25:21 are all ones, only a device with LAST_DEV set is selected.
- R7: Target bits 20:19 pick the array: 00 is the data array and 01 is the mask array. Codes 10 and 11 get no response.
- R8: Bit 29 = 0 takes the location address from bits 15:0. Bit 29 = 1 forms it as {IDX[15:2], IDX[1] | dq[1], IDX[0] | dq[0]}, where IDX is the index register named by bits 28:26.
- R9: `cmd_valid` is ignored during cycles 2 to 6 of a read in progress.
- R10: A device that is not selected keeps `ack_oe` and `dq_oe` at 0 throughout the instruction.
- R11: After reset, `ack_oe` and `dq_oe` are 0 and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid from host |
| cmd | input | 3 | Command code |
| dq_in | input | 72 | Value seen on the shared data bus |
| dq_out | output | 72 | Data this device drives onto the bus |
| dq_oe | output | 1 | Data bus output enable |
| ack_out | output | 1 | Handshake level |
| ack_oe | output | 1 | Handshake output enable |
| idx_wr_en | input | 1 | Index register write strobe |
| idx_wr_sel | input | 3 | Index register number |
| idx_wr_data | input | 16 | Index register value |
| mem_wr_en | input | 1 | Array write strobe |
| mem_wr_mask | input | 1 | 1 writes the mask array, 0 the data array |
| mem_wr_addr | input | ADDR_W | Array write location |
| mem_wr_data | input | 72 | Array write word |

## Verification
A phase counter that has slipped shows at once as the enables turning on in the wrong cycle. The bench checks every cycle of each instruction, so such a fault is caught within one cycle. A wrong selection decision shows in cycle 4 as an enable that should have stayed off, or as a missing one. A wrong captured address or array choice shows as a wrong `dq_out` word in cycle 5. A counter that re-arms while busy shows as a second handshake in the cycles after cycle 6.

// File: rtl/lookup_read_responder.sv
module lookup_read_responder #(
  parameter int          ADDR_W   = 6,
  parameter logic [3:0]  DEV_ID   = 4'h5,
  parameter logic        DEV_BANK = 1'b1,
  parameter logic        LAST_DEV = 1'b1,
  parameter logic [1:0]  READ_OPC = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd,
  input  logic [71:0]       dq_in,
  output logic [71:0]       dq_out,
  output logic              dq_oe,
  output logic              ack_out,
  output logic              ack_oe,
  input  logic              idx_wr_en,
  input  logic [2:0]        idx_wr_sel,
  input  logic [15:0]       idx_wr_data,
  input  logic              mem_wr_en,
  input  logic              mem_wr_mask,
  input  logic [ADDR_W-1:0] mem_wr_addr,
  input  logic [71:0]       mem_wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [71:0] data_mem [DEPTH];
  logic [71:0] mask_mem [DEPTH];
  logic [15:0] idx_reg  [8];

  logic [2:0]        phase;
  logic              hit_q, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [71:0]       rdata_q;

  wire start = (phase == 3'd0) && cmd_valid && !cmd[2] && (cmd[1:0] == READ_OPC);
  wire bcast = (dq_in[25:21] == 5'h1f);
  wire picked = bcast ? LAST_DEV : ((dq_in[25:22] == DEV_ID) && (dq_in[21] == DEV_BANK));
  wire tgt_ok = !dq_in[20];

  wire [15:0] ibase = idx_reg[dq_in[28:26]];
  wire [15:0] loc = dq_in[29] ? {ibase[15:2], ibase[1] | dq_in[1], ibase[0] | dq_in[0]}
                              : dq_in[15:0];

  wire unused_bits = ^{dq_in[71:30], dq_in[18:16], loc[15:ADDR_W]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= 3'd0;
      hit_q <= 1'b0;
    end else if (start) begin
      phase <= 3'd2;
      hit_q <= picked && tgt_ok;
    end else if (phase == 3'd6) begin
      phase <= 3'd0;
      hit_q <= 1'b0;
    end else if (phase != 3'd0) begin
      phase <= phase + 3'd1;
    end

  always_ff @(posedge clk) begin
    if (start) begin
      addr_q <= loc[ADDR_W-1:0];
      mask_q <= dq_in[19];
    end
    if (phase == 3'd3)
      rdata_q <= mask_q ? mask_mem[addr_q] : data_mem[addr_q];
    if (idx_wr_en)
      idx_reg[idx_wr_sel] <= idx_wr_data;
    if (mem_wr_en) begin
      if (mem_wr_mask) mask_mem[mem_wr_addr] <= mem_wr_data;
      else             data_mem[mem_wr_addr] <= mem_wr_data;
    end
  end

  assign dq_oe   = hit_q && (phase == 3'd4 || phase == 3'd5);
  assign ack_oe  = hit_q && (phase >= 3'd4);
  assign ack_out = hit_q && (phase == 3'd5);
  assign dq_out  = rdata_q;
endmodule

module lookup_read_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic dq_oe,
  input logic ack_out,
  input logic ack_oe
);
  p_dq_needs_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> ack_oe);
  p_ack_rise_after_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> $past(cmd_valid, 3));
  p_quiet_before_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> (!$past(ack_oe, 2) && !$past(dq_oe, 2)));
  p_high_only_after_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (ack_oe && dq_oe && $past(ack_oe) && !$past(ack_out)));
  p_release_after_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |=> (ack_oe && !ack_out && !dq_oe));
  p_ack_off_after_cycle6_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && !ack_out && !dq_oe) |=> !ack_oe);
endmodule

bind lookup_read_responder lookup_read_responder_chk u_chk (.*);

// File: tb/lookup_read_responder_bench.sv
module lookup_read_responder_bench;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd = 3'b0;
  logic [71:0] dq_in = '0;
  logic [71:0] dq_out;
  logic dq_oe, ack_out, ack_oe;
  logic idx_wr_en = 1'b0;
  logic [2:0] idx_wr_sel = '0;
  logic [15:0] idx_wr_data = '0;
  logic mem_wr_en = 1'b0;
  logic mem_wr_mask = 1'b0;
  logic [AW-1:0] mem_wr_addr = '0;
  logic [71:0] mem_wr_data = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lookup_read_responder #(.ADDR_W(AW)) u_lookup_read_responder (.*);

  function automatic logic [71:0] pat(input logic m, input logic [AW-1:0] a);
    return {m ? 8'h5A : 8'hA5, 58'h0, a};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // entry: {dq[29:0], hit, mask, addr}
  localparam int NV = 12;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0007, 1'b1,1'b0,6'h07},
    {1'b0,3'd0,4'h5,1'b1,2'b01,3'b0,16'h003F, 1'b1,1'b1,6'h3F},
    {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0000, 1'b1,1'b0,6'h00},
    {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'hFFC5, 1'b1,1'b0,6'h05},
    {1'b0,3'd0,4'h4,1'b1,2'b00,3'b0,16'h0007, 1'b0,1'b0,6'h00},
    {1'b0,3'd0,4'h5,1'b0,2'b00,3'b0,16'h0007, 1'b0,1'b0,6'h00},
    {1'b0,3'd0,4'hF,1'b1,2'b00,3'b0,16'h0012, 1'b1,1'b0,6'h12},
    {1'b0,3'd0,4'h5,1'b1,2'b10,3'b0,16'h0007, 1'b0,1'b0,6'h00},
    {1'b0,3'd0,4'h5,1'b1,2'b11,3'b0,16'h0007, 1'b0,1'b0,6'h00},
    {1'b1,3'd3,4'h5,1'b1,2'b00,3'b0,16'h0002, 1'b1,1'b0,6'h26},
    {1'b1,3'd5,4'h5,1'b1,2'b01,3'b0,16'h0002, 1'b1,1'b1,6'h33},
    {1'b1,3'd5,4'h5,1'b1,2'b00,3'b0,16'h0001, 1'b1,1'b0,6'h31}
  };

  task automatic run_read(input logic [2:0] c, input logic [29:0] w, input bit hit,
                          input logic [71:0] exp, input bit flood);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; dq_in = {42'h0, w};
    @(negedge clk);
    if (!flood) cmd_valid = 1'b0;
    else dq_in = {42'h0, 1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0001};
    chk(!ack_oe && !dq_oe, "R2/R10 cycle2 quiet", {ack_oe, dq_oe}, 0);
    @(negedge clk);
    chk(!ack_oe && !dq_oe, "R2/R10 cycle3 quiet", {ack_oe, dq_oe}, 0);
    @(negedge clk);
    chk(ack_oe == hit && dq_oe == hit && !ack_out, "R3/R6/R10 cycle4",
        {ack_oe, dq_oe, ack_out}, {hit, hit, 1'b0});
    @(negedge clk);
    chk(ack_out == hit && dq_oe == hit, "R4 cycle5 handshake", {ack_out, dq_oe}, {hit, hit});
    if (hit) chk(dq_out == exp, "R4/R7/R8 cycle5 data", dq_out, exp);
    @(negedge clk);
    chk(!dq_oe && ack_oe == hit && !ack_out, "R5 cycle6", {dq_oe, ack_oe, ack_out}, {1'b0, hit, 1'b0});
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!ack_oe && !dq_oe, "R5 cycle7 released", {ack_oe, dq_oe}, 0);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack_oe && !dq_oe, "R11 reset enables", {ack_oe, dq_oe}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      idx_wr_en = 1'b1; idx_wr_sel = 3'(k);
      idx_wr_data = (k == 3) ? 16'h0024 : (k == 5) ? 16'h0031 : 16'hFFFF;
    end
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << AW); a++) begin
        @(negedge clk);
        idx_wr_en = 1'b0;
        mem_wr_en = 1'b1; mem_wr_mask = m[0]; mem_wr_addr = AW'(a);
        mem_wr_data = pat(m[0], AW'(a));
      end
    @(negedge clk);
    mem_wr_en = 1'b0;
    chk(!ack_oe && !dq_oe, "R11 idle after reset", {ack_oe, dq_oe}, 0);

    for (int i = 0; i < NV; i++)
      run_read(3'b001, VEC[i][37:8], VEC[i][7], pat(VEC[i][6], VEC[i][5:0]), 1'b0);

    // R1: wrong opcode and cmd[2] set are not reads
    run_read(3'b101, {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0007}, 1'b0, '0, 1'b0);
    run_read(3'b000, {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0007}, 1'b0, '0, 1'b0);
    run_read(3'b011, {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0007}, 1'b0, '0, 1'b0);

    // R9: cmd_valid held through cycles 2 to 6 is ignored
    run_read(3'b001, {1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h000A}, 1'b1, pat(1'b0, 6'h0A), 1'b1);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(!ack_oe && !dq_oe, "R9 no extra read", {ack_oe, dq_oe}, 0);
    end

    // R5: back-to-back read right after cycle 6
    run_read(3'b001, {1'b0,3'd0,4'h5,1'b1,2'b01,3'b0,16'h0002}, 1'b1, pat(1'b1, 6'h02), 1'b0);

    // R11: reset mid-read drops the enables
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'b001; dq_in = {42'h0, 1'b0,3'd0,4'h5,1'b1,2'b00,3'b0,16'h0003};
    @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0;
    #1 chk(!ack_oe && !dq_oe, "R11 reset mid-read", {ack_oe, dq_oe}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_oe && !dq_oe, "R11 idle after mid reset", {ack_oe, dq_oe}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule